// File: doc/BRIEF.md
# Bus Abort Status Capture Unit

This unit sits beside the bus fabric and watches accesses from a set of bus masters (two by default). Three external checkers tell it, per master and per cycle, whether the current access targets an address no slave decodes, whether the access is misaligned, or whether it breaks a protection rule. Any of these on a valid access raises one abort line. That line goes to every master in the same cycle, whichever master issued the faulting access.

On each abort the unit records the full access address, the request size, the access type, which of the three causes applied, and which master issued the access. It also keeps one sticky flag per master. A master's flag records that it aborted while another record took or kept the master-identity field, so that no abort is lost between two software reads. Software reads both the address word and the status word through a simple combinational read port. A read of the status word clears the sticky flags.

Top module: `abort_status_unit`

## Requirements
- R1: While reset is held and after it is released, the address word and the status word both read as zero until the first abort.
- R2: `abort_o` is high in exactly those cycles in which some master has `m_valid` set together with at least one of its three cause inputs. A cause input on a master whose `m_valid` is low has no effect on `abort_o` or on any recorded field.
- R3: On an abort, the address word (`rd_sel`=0) shows the full address of the recorded access from the next clock on.
- R4: Status bits [1:0] hold the recorded size (00 byte, 01 halfword, 10 word). Status bits [3:2] hold the recorded type (00 fetch, 01 read, 10 write).
- R5: Status bit 8 marks an undefined address, bit 9 a misaligned address and bit 10 a protection violation for the recorded access. Every cause present on that access is set together.
- R6: Status bits [17:16] are one-hot and name the master of the recorded access (bit 16 for master 0). When both masters abort in the same cycle, master 0 is recorded.
- R7: Status bits [25:24] are per-master sticky flags (bit 24 for master 0). A flag is set when that master aborts in a cycle in which it is not recorded. It is also set when that master held the identity bits and an abort by the other master displaces it. It is not set when the master's own abort is the one recorded.
- R8: A read with `rd_en`=1 and `rd_sel`=1 clears both sticky flags at the next clock. An abort in that same cycle that would set a flag leaves that flag set. A read of the address word does not clear them.
- R9: A later abort overwrites the address, size, type, cause and master fields. Without an abort, every recorded field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | NM | Per-master access valid |
| m_addr | input | NM*AW | Per-master access address, master g at bits [g*AW +: AW] |
| m_size | input | NM*2 | Per-master access size code |
| m_type | input | NM*2 | Per-master access type code |
| undef_hit | input | NM | Per-master undefined-address flag from the decoder |
| misalign_hit | input | NM | Per-master misalignment flag from the alignment checker |
| prot_hit | input | NM | Per-master violation flag from the protection checker |
| abort_o | output | 1 | Abort broadcast to all masters |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects the address word, 1 selects the status word |
| rd_data | output | 32 | Read data, combinational from the recorded state |

## Verification
The assertions take the three cause inputs as meaningful only alongside `m_valid`. They also assume that size and type codes arrive already encoded, so a reserved code 11 is recorded as given and never checked. The stimulus draws size and type only from the defined codes. It pulses causes both with and without `m_valid`, drives same-cycle aborts from both masters, and places status reads in the same cycle as aborts. Each of these input conditions therefore appears in the run while staying inside the stated assumptions.

// File: rtl/abort_pkg.sv
package abort_pkg;

  localparam int CAUSE_W = 3;
  localparam int CODE_W  = 2;

  localparam int C_UNDEF = 0;
  localparam int C_ALIGN = 1;
  localparam int C_PROT  = 2;

  localparam int ST_SIZE_LSB  = 0;
  localparam int ST_TYPE_LSB  = 2;
  localparam int ST_CAUSE_LSB = 8;
  localparam int ST_MST_LSB   = 16;
  localparam int ST_STK_LSB   = 24;

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic [CODE_W-1:0]  kind;
    logic [CODE_W-1:0]  size;
  } meta_t;

endpackage

// File: rtl/abort_detect.sv
module abort_detect
  import abort_pkg::*;
#(
  parameter int NM = 2,
  parameter int AW = 32
) (
  input  logic [NM-1:0]        m_valid,
  input  logic [NM*AW-1:0]     m_addr,
  input  logic [NM*CODE_W-1:0] m_size,
  input  logic [NM*CODE_W-1:0] m_type,
  input  logic [NM-1:0]        undef_hit,
  input  logic [NM-1:0]        misalign_hit,
  input  logic [NM-1:0]        prot_hit,
  output logic [NM-1:0]        hit,
  output logic [NM-1:0]        win,
  output logic [AW-1:0]        win_addr,
  output meta_t                win_meta
);

  logic [NM*CAUSE_W-1:0] cause_all;

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_mst
      logic [CAUSE_W-1:0] raw;
      always_comb begin
        raw          = '0;
        raw[C_UNDEF] = undef_hit[g];
        raw[C_ALIGN] = misalign_hit[g];
        raw[C_PROT]  = prot_hit[g];
      end
      assign cause_all[g*CAUSE_W +: CAUSE_W] = raw & {CAUSE_W{m_valid[g]}};
      assign hit[g] = |cause_all[g*CAUSE_W +: CAUSE_W];
    end
  endgenerate

  // lowest index has priority
  always_comb begin
    logic taken;
    taken = 1'b0;
    win   = '0;
    for (int i = 0; i < NM; i++) begin
      if (hit[i] && !taken) begin
        win[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  always_comb begin
    win_addr = '0;
    win_meta = '0;
    for (int i = 0; i < NM; i++) begin
      if (win[i]) begin
        win_addr       = m_addr[i*AW +: AW];
        win_meta.size  = m_size[i*CODE_W +: CODE_W];
        win_meta.kind  = m_type[i*CODE_W +: CODE_W];
        win_meta.cause = cause_all[i*CAUSE_W +: CAUSE_W];
      end
    end
  end

endmodule

// File: rtl/abort_capture.sv
module abort_capture
  import abort_pkg::*;
#(
  parameter int NM = 2,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NM-1:0] win,
  input  logic [AW-1:0] win_addr,
  input  meta_t         win_meta,
  output logic [AW-1:0] addr_q,
  output meta_t         meta_q,
  output logic [NM-1:0] mst_q
);

  logic [AW-1:0] addr_d;
  meta_t         meta_d;
  logic [NM-1:0] mst_d;

  always_comb begin
    addr_d = addr_q;
    meta_d = meta_q;
    mst_d  = mst_q;
    if (load) begin
      addr_d = win_addr;
      meta_d = win_meta;
      mst_d  = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      meta_q <= '0;
      mst_q  <= '0;
    end else if (load) begin
      addr_q <= addr_d;
      meta_q <= meta_d;
      mst_q  <= mst_d;
    end
  end

endmodule

// File: rtl/abort_sticky.sv
module abort_sticky #(
  parameter int NM = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [NM-1:0] hit,
  input  logic [NM-1:0] win,
  input  logic [NM-1:0] mst_q,
  output logic [NM-1:0] sticky_q
);

  logic [NM-1:0] lost;
  logic [NM-1:0] displaced;
  logic [NM-1:0] sticky_d;
  logic          upd;

  always_comb begin
    lost      = hit & ~win;
    displaced = load ? (mst_q & ~win) : '0;
    sticky_d  = (clr ? '0 : sticky_q) | lost | displaced;
    upd       = clr | (|lost) | (|displaced);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else if (upd) begin
      sticky_q <= sticky_d;
    end
  end

endmodule

// File: rtl/abort_status_unit.sv
module abort_status_unit
  import abort_pkg::*;
#(
  parameter int NM = 2,
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NM-1:0]       m_valid,
  input  logic [NM*AW-1:0]    m_addr,
  input  logic [NM*2-1:0]     m_size,
  input  logic [NM*2-1:0]     m_type,
  input  logic [NM-1:0]       undef_hit,
  input  logic [NM-1:0]       misalign_hit,
  input  logic [NM-1:0]       prot_hit,
  output logic                abort_o,
  input  logic                rd_en,
  input  logic                rd_sel,
  output logic [31:0]         rd_data
);

  localparam int RD_W = 32;

  logic [NM-1:0]      hit;
  logic [NM-1:0]      win;
  logic [AW-1:0]      win_addr;
  meta_t              win_meta;
  logic [AW-1:0]      addr_q;
  meta_t              meta_q;
  logic [NM-1:0]      mst_q;
  logic [NM-1:0]      sticky_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               any_hit;
  logic               stat_clr;
  logic [RD_W-1:0]    status_word;

  abort_detect #(.NM(NM), .AW(AW)) u_detect (
    .m_valid      (m_valid),
    .m_addr       (m_addr),
    .m_size       (m_size),
    .m_type       (m_type),
    .undef_hit    (undef_hit),
    .misalign_hit (misalign_hit),
    .prot_hit     (prot_hit),
    .hit          (hit),
    .win          (win),
    .win_addr     (win_addr),
    .win_meta     (win_meta)
  );

  assign any_hit  = |hit;
  assign stat_clr = rd_en & rd_sel;

  abort_capture #(.NM(NM), .AW(AW)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (any_hit),
    .win      (win),
    .win_addr (win_addr),
    .win_meta (win_meta),
    .addr_q   (addr_q),
    .meta_q   (meta_q),
    .mst_q    (mst_q)
  );

  abort_sticky #(.NM(NM)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stat_clr),
    .load     (any_hit),
    .hit      (hit),
    .win      (win),
    .mst_q    (mst_q),
    .sticky_q (sticky_q)
  );

  assign cause_q = meta_q.cause;
  assign abort_o = any_hit;

  always_comb begin
    status_word = '0;
    status_word[ST_SIZE_LSB  +: CODE_W]  = meta_q.size;
    status_word[ST_TYPE_LSB  +: CODE_W]  = meta_q.kind;
    status_word[ST_CAUSE_LSB +: CAUSE_W] = meta_q.cause;
    status_word[ST_MST_LSB   +: NM]      = mst_q;
    status_word[ST_STK_LSB   +: NM]      = sticky_q;
  end

  always_comb begin
    if (rd_sel) rd_data = status_word;
    else        rd_data = RD_W'(addr_q);
  end

endmodule

// File: rtl/abort_status_checker.sv
module abort_status_checker #(
  parameter int NM = 2,
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    m_valid,
  input logic [NM*AW-1:0] m_addr,
  input logic [NM-1:0]    undef_hit,
  input logic [NM-1:0]    misalign_hit,
  input logic [NM-1:0]    prot_hit,
  input logic             abort_o,
  input logic             rd_en,
  input logic             rd_sel,
  input logic [AW-1:0]    addr_q,
  input logic [2:0]       cause_q,
  input logic [NM-1:0]    mst_q,
  input logic [NM-1:0]    sticky_q
);

  logic m0_bad;
  assign m0_bad = m_valid[0] & (undef_hit[0] | misalign_hit[0] | prot_hit[0]);

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (addr_q == '0 && cause_q == '0 && mst_q == '0 && sticky_q == '0));

  p_abort_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (m_valid != '0));

  p_no_valid_no_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid == '0) |-> !abort_o);

  p_addr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m0_bad |=> (addr_q == $past(m_addr[AW-1:0])));

  p_cause_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (cause_q != '0));

  p_master_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_q));

  p_master0_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m0_bad |=> mst_q[0]);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !abort_o) |=> (sticky_q == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_o |=> ($stable(addr_q) && $stable(cause_q) && $stable(mst_q)));

endmodule

bind abort_status_unit abort_status_checker #(.NM(NM), .AW(AW)) u_chk (.*);

// File: tb/abort_status_unit_test.sv
module abort_status_unit_test;

  localparam int NM = 2;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NM-1:0]   m_valid;
  logic [NM*AW-1:0] m_addr;
  logic [NM*2-1:0] m_size;
  logic [NM*2-1:0] m_type;
  logic [NM-1:0]   undef_hit, misalign_hit, prot_hit;
  logic            abort_o;
  logic            rd_en, rd_sel;
  logic [31:0]     rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string req = "R1";

  // reference state
  logic [31:0] r_addr;
  logic [1:0]  r_size, r_type;
  logic [2:0]  r_cause;
  logic [1:0]  r_mst, r_stk;

  always #2 clk = ~clk;

  abort_status_unit #(.NM(NM), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr),
    .m_size(m_size), .m_type(m_type), .undef_hit(undef_hit),
    .misalign_hit(misalign_hit), .prot_hit(prot_hit), .abort_o(abort_o),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [31:0] status_exp();
    logic [31:0] w;
    w = 32'(r_size) | (32'(r_type) << 2) | (32'(r_cause) << 8)
      | (32'(r_mst) << 16) | (32'(r_stk) << 24);
    return w;
  endfunction

  function automatic logic [2:0] cause_of(int m);
    if (!m_valid[m]) return 3'b000;
    return {prot_hit[m], misalign_hit[m], undef_hit[m]};
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] v, logic [31:0] a0, logic [31:0] a1,
                       logic [3:0] sz, logic [3:0] ty, logic [1:0] u,
                       logic [1:0] mi, logic [1:0] p, logic re, logic rs);
    m_valid = v; m_addr = {a1, a0}; m_size = sz; m_type = ty;
    undef_hit = u; misalign_hit = mi; prot_hit = p; rd_en = re; rd_sel = rs;
  endtask

  // one cycle: compare, advance model, move to next falling edge
  task automatic cyc();
    logic [2:0] c0, c1;
    logic [1:0] h, w, stk_n;
    logic       exp_ab;
    #1;
    c0 = cause_of(0); c1 = cause_of(1);
    h = {|c1, |c0};
    exp_ab = |h;
    check("abort_o", 32'(abort_o), 32'(exp_ab));
    check(rd_sel ? "status" : "address", rd_data,
          rd_sel ? status_exp() : r_addr);
    w = h[0] ? 2'b01 : (h[1] ? 2'b10 : 2'b00);
    stk_n = (rd_en && rd_sel) ? 2'b00 : r_stk;
    stk_n = stk_n | (h & ~w);
    if (exp_ab) stk_n = stk_n | (r_mst & ~w);
    @(posedge clk);
    if (rst_n) begin
      r_stk = stk_n;
      if (exp_ab) begin
        r_mst = w;
        if (w[0]) begin
          r_addr = m_addr[31:0]; r_size = m_size[1:0]; r_type = m_type[1:0]; r_cause = c0;
        end else begin
          r_addr = m_addr[63:32]; r_size = m_size[3:2]; r_type = m_type[3:2]; r_cause = c1;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(logic rs);
    drive(2'b00, 32'h0, 32'h0, 4'h0, 4'h0, 2'b00, 2'b00, 2'b00, 1'b0, rs);
  endtask

  initial begin
    r_addr = '0; r_size = '0; r_type = '0; r_cause = '0; r_mst = '0; r_stk = '0;
    rst_n = 1'b0;
    idle(1'b0);
    @(negedge clk);
    // R1: zero under reset, both words
    req = "R1";
    for (int i = 0; i < 4; i++) begin
      rd_sel = i[0];
      cyc();
    end
    rst_n = 1'b1;
    idle(1'b1); cyc();
    idle(1'b0); cyc();

    // R2: causes without valid are ignored
    req = "R2";
    drive(2'b00, 32'hDEAD0001, 32'hBEEF0002, 4'h9, 4'h6, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1);
    cyc();
    idle(1'b1); cyc();
    drive(2'b10, 32'h0, 32'h1234, 4'h0, 4'h0, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);
    cyc();
    idle(1'b0); cyc();

    // R3/R4/R5: single master-0 abort, each cause alone and all together
    req = "R3";
    drive(2'b01, 32'hFFFF_FFFC, 32'h0, 4'h2, 4'h1, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0);
    cyc(); idle(1'b0); cyc();
    req = "R4";
    drive(2'b01, 32'h0000_0101, 32'h0, 4'h1, 4'h2, 2'b00, 2'b01, 2'b00, 1'b0, 1'b1);
    cyc(); idle(1'b1); cyc();
    req = "R5";
    drive(2'b01, 32'h8000_0000, 32'h0, 4'h0, 4'h0, 2'b00, 2'b00, 2'b01, 1'b0, 1'b1);
    cyc(); idle(1'b1); cyc();
    drive(2'b01, 32'h8000_0003, 32'h0, 4'h2, 4'h2, 2'b01, 2'b01, 2'b01, 1'b0, 1'b1);
    cyc(); idle(1'b1); cyc();

    // R6/R7: simultaneous aborts, master 0 recorded, master 1 sticky
    req = "R6";
    drive(2'b11, 32'h1111_0000, 32'h2222_0000, 4'h6, 4'h9, 2'b01, 2'b00, 2'b10, 1'b0, 1'b1);
    cyc(); idle(1'b0); cyc(); idle(1'b1); cyc();
    // R7: master 1 displaces master 0
    req = "R7";
    drive(2'b10, 32'h0, 32'h3333_0004, 4'h0, 4'h4, 2'b00, 2'b10, 2'b00, 1'b0, 1'b1);
    cyc(); idle(1'b1); cyc();

    // R8: address read keeps flags, status read clears next clock
    req = "R8";
    drive(2'b00, 32'h0, 32'h0, 4'h0, 4'h0, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0);
    cyc(); idle(1'b1); cyc();
    drive(2'b00, 32'h0, 32'h0, 4'h0, 4'h0, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1);
    cyc(); idle(1'b1); cyc();
    // R8: read in the same cycle as a losing abort keeps that flag
    drive(2'b11, 32'h4444_0000, 32'h5555_0000, 4'h5, 4'h5, 2'b11, 2'b00, 2'b00, 1'b1, 1'b1);
    cyc(); idle(1'b1); cyc();

    // R9: repeated aborts overwrite, idle holds
    req = "R9";
    drive(2'b01, 32'hA5A5_A5A4, 32'h0, 4'h1, 4'h0, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0);
    cyc(); idle(1'b0); cyc(); cyc(); idle(1'b1); cyc();

    // mixed stimulus across all requirements
    req = "R7";
    for (int i = 0; i < 600; i++) begin
      logic [1:0] v, u, mi, p;
      logic [3:0] sz, ty;
      v  = 2'($urandom_range(0, 3));
      u  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      mi = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      p  = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      sz = {2'($urandom_range(0, 2)), 2'($urandom_range(0, 2))};
      ty = {2'($urandom_range(0, 2)), 2'($urandom_range(0, 2))};
      drive(v, $urandom, $urandom, sz, ty, u, mi, p,
            ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)));
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule